// File: doc/BRIEF.md
# Dual-Converter Serial Read Sequencer

This block is the host-side master for a dual successive-approximation converter that shares one serial clock and one active-low chip select and returns its results on two serial data lines. The host issues a command over a valid/ready handshake. The block then builds the frame on the converter pins and, for conversions, hands back both 12-bit results and their tag bits over a second valid/ready handshake. It divides the system clock down to the serial clock and keeps the required quiet time between frames.

The block supports two conversion reads. A normal read takes 16 bits from each line. A chained read takes 32 bits from line A alone and routes each 16-bit word by its converter-identity bit. Power control uses truncated frames: chip select rises between the 8th and 9th serial clock falling edges. A partial power-down uses one such frame and a full power-down uses two. A wake command sends a full-length dummy frame whose data is thrown away. After a wake from full power-down, the block holds off the next frame for a further programmable settle time.

Top module: `adc_dual_read_seq`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_sclk` are high, `res_valid` is low, and `cmd_ready` is high.
- R2: A normal conversion (op code 0) holds `adc_cs_n` low for exactly 16 `adc_sclk` falling edges. `adc_sclk` is high whenever `adc_cs_n` is high.
- R3: The converter presents bit 15 of its word when `adc_cs_n` falls and the next bit after each `adc_sclk` falling edge. The block samples each bit at the following falling edge, so bit 0 is taken at the 16th falling edge. Word layout: bit 15 is the leading zero, bit 14 is a status bit that is always zero, bit 13 is the converter identity (0 = A, 1 = B), bit 12 is the input-pair tag, and bits 11:0 are the data, MSB first. For a normal read, the word on line A goes to `res_data_a`/`res_pair_a` and the word on line B goes to `res_data_b`/`res_pair_b`. `res_valid` rises in the cycle in which `adc_cs_n` returns high.
- R4: A chained conversion (op code 1) gives exactly 32 falling edges and reads line A only. Of the two words received, the one with identity 0 is reported as A and the one with identity 1 as B, in either arrival order.
- R5: `res_err` is 1 if the leading zero or the zero status bit of either word reads 1. It is also 1 if the identities are wrong: for a normal read, line A must carry 0 and line B must carry 1; for a chained read, the two identities must differ.
- R6: Partial power-down (op code 2) sends one frame of exactly 8 falling edges, and `adc_cs_n` rises before the 9th. It produces no result.
- R7: Full power-down (op code 3) sends two such 8-edge frames and produces no result.
- R8: Wake (op code 4) sends one 16-edge frame and produces no result.
- R9: Between any two frames, `adc_cs_n` stays high for at least `QUIET_CYC` clock cycles.
- R10: After a wake that follows a full power-down, `adc_cs_n` stays high for at least `QUIET_CYC + WAKE_CYC` cycles before the next frame. After a wake that follows a partial power-down, only the quiet time applies.
- R11: `cmd_ready` is high only when the block is idle and no result is pending. The result outputs hold steady while `res_valid` is high and `res_ready` is low.
- R12: Op codes 5, 6 and 7 are accepted and ignored: no frame is sent and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command op code (0..4, see requirements) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_dout_a | input | 1 | Serial data line from converter A |
| adc_dout_b | input | 1 | Serial data line from converter B |
| res_valid | output | 1 | Result pending |
| res_ready | input | 1 | Host takes the result |
| res_data_a | output | 12 | Converter A data |
| res_data_b | output | 12 | Converter B data |
| res_pair_a | output | 1 | Converter A input-pair tag |
| res_pair_b | output | 1 | Converter B input-pair tag |
| res_err | output | 1 | Word check failed |

## Verification
The host can consume a result in the same cycle in which it offers the next command. The block must keep the command waiting until the result has been taken, and it must not start a frame early. The bench provokes this by leaving a result unconsumed and holding `cmd_valid` high for several cycles. It checks that `cmd_ready` stays low and that chip select does not move. It then pulses `res_ready` and confirms that the held command runs afterwards and returns its own correct result. The quiet-time and settle-time windows are judged from the chip-select high time measured at the pins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W      = 12;
    localparam int WORD_W      = 16;
    localparam int STREAM_W    = 2 * WORD_W;
    localparam int FALL_W      = 6;
    localparam int PD_FALLS    = 8;
    localparam int CONV_FALLS  = WORD_W;
    localparam int CHAIN_FALLS = STREAM_W;

    typedef enum logic [2:0] {
        OP_CONV    = 3'd0,
        OP_CHAIN   = 3'd1,
        OP_PD_PART = 3'd2,
        OP_PD_FULL = 3'd3,
        OP_WAKE    = 3'd4
    } op_e;

    // serial word as it arrives, MSB first
    typedef struct packed {
        logic              lead;
        logic              zflag;
        logic              src;
        logic              pair;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic [DATA_W-1:0] data_a;
        logic [DATA_W-1:0] data_b;
        logic              pair_a;
        logic              pair_b;
        logic              err;
    } result_t;

    function automatic logic word_bad(input word_t w);
        return w.lead | w.zflag;
    endfunction

endpackage

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
    parameter int HALF = 2,
    parameter int FW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] falls_req,
    output logic          cs_n,
    output logic          sclk,
    output logic          sample,
    output logic          done
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} ph_e;

    ph_e           ph;
    logic [TW-1:0] tcnt;
    logic [FW-1:0] fcnt;
    logic [FW-1:0] req_q;
    logic          tlast;

    assign tlast = (tcnt == TW'(HALF - 1));

    always_comb begin
        sample = tlast && ((ph == PH_SETUP) || (ph == PH_HIGH && fcnt != req_q));
        done   = tlast && (ph == PH_HIGH) && (fcnt == req_q);
        cs_n   = (ph == PH_IDLE);
        sclk   = (ph != PH_LOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            tcnt  <= '0;
            fcnt  <= '0;
            req_q <= '0;
        end else if (ph == PH_IDLE) begin
            if (start) begin
                ph    <= PH_SETUP;
                tcnt  <= '0;
                fcnt  <= '0;
                req_q <= falls_req;
            end
        end else if (!tlast) begin
            tcnt <= tcnt + 1'b1;
        end else begin
            tcnt <= '0;
            case (ph)
                PH_SETUP: begin
                    ph   <= PH_LOW;
                    fcnt <= fcnt + 1'b1;
                end
                PH_LOW: ph <= PH_HIGH;
                default: begin
                    if (fcnt == req_q) begin
                        ph <= PH_IDLE;
                    end else begin
                        ph   <= PH_LOW;
                        fcnt <= fcnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc_seq_sort.sv
module adc_seq_sort
    import adc_seq_pkg::*;
(
    input  logic                chain,
    input  logic [STREAM_W-1:0] stream_a,
    input  logic [WORD_W-1:0]   word_b,
    output result_t             res
);
    word_t w_hi, w_lo, w_b, first, second;
    logic  id_bad;

    assign w_hi = word_t'(stream_a[STREAM_W-1:WORD_W]);
    assign w_lo = word_t'(stream_a[WORD_W-1:0]);
    assign w_b  = word_t'(word_b);

    always_comb begin
        if (chain) begin
            first  = w_hi.src ? w_lo : w_hi;
            second = w_hi.src ? w_hi : w_lo;
            id_bad = (w_hi.src == w_lo.src);
        end else begin
            first  = w_lo;
            second = w_b;
            id_bad = w_lo.src | ~w_b.src;
        end
        res.data_a = first.data;
        res.pair_a = first.pair;
        res.data_b = second.data;
        res.pair_b = second.pair;
        res.err    = word_bad(first) | word_bad(second) | id_bad;
    end
endmodule

// File: rtl/adc_dual_read_seq.sv
module adc_dual_read_seq
    import adc_seq_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int QUIET_CYC = 6,
    parameter int WAKE_CYC  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_dout_a,
    input  logic              adc_dout_b,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data_a,
    output logic [DATA_W-1:0] res_data_b,
    output logic              res_pair_a,
    output logic              res_pair_b,
    output logic              res_err
);
    localparam int MAX_WAIT = (QUIET_CYC > WAKE_CYC) ? QUIET_CYC : WAKE_CYC;
    localparam int CW       = $clog2(MAX_WAIT + 1);

    typedef enum logic [1:0] {S_IDLE, S_FRAME, S_QUIET, S_SETTLE} st_e;

    st_e                 st;
    logic [CW-1:0]       cnt;
    logic                second_q, chain_q, conv_q, long_wake_q, full_pd_q;
    result_t             res_q, sorted;
    logic                accept, op_known, start, f_sample, f_done, q_last;
    logic [FALL_W-1:0]   falls_req;
    logic [STREAM_W-1:0] sh_a;
    logic [WORD_W-1:0]   sh_b;
    op_e                 op;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = (st == S_IDLE) && !res_valid;
    assign accept    = cmd_valid && cmd_ready;
    assign op_known  = (cmd_op <= 3'd4);
    assign q_last    = (cnt == CW'(QUIET_CYC - 1));
    assign start     = (accept && op_known) || (st == S_QUIET && q_last && second_q);

    always_comb begin
        falls_req = FALL_W'(PD_FALLS);
        if (st == S_IDLE) begin
            case (op)
                OP_CONV, OP_WAKE: falls_req = FALL_W'(CONV_FALLS);
                OP_CHAIN:         falls_req = FALL_W'(CHAIN_FALLS);
                default:          falls_req = FALL_W'(PD_FALLS);
            endcase
        end
    end

    adc_seq_frame #(.HALF(SCLK_HALF), .FW(FALL_W)) u_frame (
        .clk(clk), .rst(rst), .start(start), .falls_req(falls_req),
        .cs_n(adc_cs_n), .sclk(adc_sclk), .sample(f_sample), .done(f_done)
    );

    adc_seq_shift #(.W(STREAM_W)) u_shift_a (
        .clk(clk), .rst(rst), .clr(start), .en(f_sample), .din(adc_dout_a), .q(sh_a)
    );

    adc_seq_shift #(.W(WORD_W)) u_shift_b (
        .clk(clk), .rst(rst), .clr(start), .en(f_sample), .din(adc_dout_b), .q(sh_b)
    );

    adc_seq_sort u_sort (
        .chain(chain_q), .stream_a(sh_a), .word_b(sh_b), .res(sorted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            cnt         <= '0;
            second_q    <= 1'b0;
            chain_q     <= 1'b0;
            conv_q      <= 1'b0;
            long_wake_q <= 1'b0;
            full_pd_q   <= 1'b0;
            res_valid   <= 1'b0;
            res_q       <= '0;
        end else begin
            if (res_valid && res_ready) res_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (accept && op_known) begin
                        st      <= S_FRAME;
                        chain_q <= (op == OP_CHAIN);
                        conv_q  <= (op == OP_CONV) || (op == OP_CHAIN);
                        case (op)
                            OP_PD_PART: full_pd_q <= 1'b0;
                            OP_PD_FULL: begin
                                full_pd_q <= 1'b1;
                                second_q  <= 1'b1;
                            end
                            OP_WAKE: begin
                                long_wake_q <= full_pd_q;
                                full_pd_q   <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                S_FRAME: begin
                    if (f_done) begin
                        st  <= S_QUIET;
                        cnt <= '0;
                        if (conv_q) begin
                            res_q     <= sorted;
                            res_valid <= 1'b1;
                        end
                    end
                end
                S_QUIET: begin
                    if (q_last) begin
                        cnt <= '0;
                        if (second_q) begin
                            second_q <= 1'b0;
                            st       <= S_FRAME;
                        end else if (long_wake_q) begin
                            long_wake_q <= 1'b0;
                            st          <= S_SETTLE;
                        end else begin
                            st <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(WAKE_CYC - 1)) begin
                        cnt <= '0;
                        st  <= S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign res_data_a = res_q.data_a;
    assign res_data_b = res_q.data_b;
    assign res_pair_a = res_q.pair_a;
    assign res_pair_b = res_q.pair_b;
    assign res_err    = res_q.err;

endmodule

// File: rtl/adc_dual_read_seq_chk.sv
module adc_dual_read_seq_chk #(
    parameter int QUIET_CYC = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_ready,
    input logic        adc_cs_n,
    input logic        adc_sclk,
    input logic        res_valid,
    input logic        res_ready,
    input logic [11:0] res_data_a,
    input logic [11:0] res_data_b,
    input logic        res_err
);
    logic        sclk_q, seen_frame, fall_w;
    logic [5:0]  fcnt;
    logic [15:0] hcnt;

    assign fall_w = sclk_q && !adc_sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b1;
            fcnt       <= '0;
            hcnt       <= '0;
            seen_frame <= 1'b0;
        end else begin
            sclk_q <= adc_sclk;
            if (adc_cs_n) fcnt <= '0;
            else if (fall_w) fcnt <= fcnt + 1'b1;
            if (adc_cs_n) hcnt <= (hcnt == 16'hFFFF) ? hcnt : hcnt + 1'b1;
            else hcnt <= '0;
            if (!adc_cs_n) seen_frame <= 1'b1;
        end
    end

    assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    assert_frame_len_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (fcnt == 6'd8 || fcnt == 6'd16 || fcnt == 6'd32));

    assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_cs_n) && seen_frame) |-> (hcnt >= 16'(QUIET_CYC)));

    assert_cmd_gate_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !cmd_ready);

    assert_res_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data_a)
                                       && $stable(res_data_b) && $stable(res_err)));

    assert_res_at_cs_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> adc_cs_n);

endmodule

bind adc_dual_read_seq adc_dual_read_seq_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .res_valid(res_valid), .res_ready(res_ready),
    .res_data_a(res_data_a), .res_data_b(res_data_b), .res_err(res_err)
);

// File: tb/adc_dual_read_seq_tb.sv
module adc_dual_read_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int QUIET      = 6;
    localparam int WAKE       = 40;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst, cmd_valid, cmd_ready, res_ready, res_valid;
    logic [2:0]  cmd_op;
    logic        adc_cs_n, adc_sclk, adc_dout_a, adc_dout_b;
    logic [11:0] res_data_a, res_data_b;
    logic        res_pair_a, res_pair_b, res_err;

    int total = 0;
    int bad   = 0;

    logic [31:0] stream_a = '0;
    logic [15:0] word_b   = '0;
    logic        cs_prev, sclk_prev;
    int          k, hi_cnt, gap_last, falls_last, falls_prev, frames_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_dual_read_seq #(.SCLK_HALF(HALF), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_dout_a(adc_dout_a), .adc_dout_b(adc_dout_b), .res_valid(res_valid),
        .res_ready(res_ready), .res_data_a(res_data_a), .res_data_b(res_data_b),
        .res_pair_a(res_pair_a), .res_pair_b(res_pair_b), .res_err(res_err)
    );

    // converter model and pin monitor
    initial begin
        k = 0; hi_cnt = 0; gap_last = 0; falls_last = 0; falls_prev = 0; frames_done = 0;
        cs_prev = 1'b1; sclk_prev = 1'b1; adc_dout_a = 1'b0; adc_dout_b = 1'b0;
    end

    always @(negedge clk) begin
        if (rst) begin
            cs_prev = 1'b1; sclk_prev = 1'b1; hi_cnt = 0; k = 0;
            adc_dout_a = 1'b0; adc_dout_b = 1'b0;
        end else begin
            if (!adc_cs_n && cs_prev) begin
                gap_last = hi_cnt;
                k = 0;
            end else if (!adc_cs_n && sclk_prev && !adc_sclk) begin
                k = k + 1;
            end
            if (adc_cs_n && !cs_prev) begin
                falls_prev = falls_last;
                falls_last = k;
                frames_done = frames_done + 1;
            end
            if (adc_cs_n) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
            adc_dout_a = (!adc_cs_n && k < 32) ? stream_a[31-k] : 1'b0;
            adc_dout_b = (!adc_cs_n && k < 16) ? word_b[15-k] : 1'b0;
            cs_prev = adc_cs_n;
            sclk_prev = adc_sclk;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic lead, input logic z, input logic src,
                                       input logic pair, input logic [11:0] d);
        return {lead, z, src, pair, d};
    endfunction

    task automatic send(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_conv(input logic chain, input logic [31:0] sa, input logic [15:0] wb,
                           input logic [11:0] ea, input logic [11:0] eb, input logic pa,
                           input logic pb, input logic err, input bit gapchk, input bit keep,
                           input string tag);
        stream_a = sa;
        word_b   = wb;
        send(chain ? 3'd1 : 3'd0);
        wait (res_valid === 1'b1);
        @(negedge clk); #1;
        if (chain) chk(falls_last == 32, "R4 falls", falls_last, 32);
        else       chk(falls_last == 16, "R2 falls", falls_last, 16);
        if (gapchk) chk(gap_last >= QUIET, "R9 quiet", gap_last, QUIET);
        chk(res_data_a == ea, tag, res_data_a, ea);
        chk(res_data_b == eb, tag, res_data_b, eb);
        chk(res_pair_a == pa && res_pair_b == pb, tag, {res_pair_a, res_pair_b}, {pa, pb});
        chk(res_err == err, "R5 err", res_err, err);
        if (!keep) begin
            res_ready = 1'b1;
            @(negedge clk);
            res_ready = 1'b0;
        end
    endtask

    task automatic do_pd(input logic [2:0] op, input int n);
        int f0;
        f0 = frames_done;
        send(op);
        wait (frames_done == f0 + n);
        @(negedge clk); #1;
        chk(falls_last == 8, "R6 pd falls", falls_last, 8);
        if (n == 2) begin
            chk(falls_prev == 8, "R7 first pd falls", falls_prev, 8);
            chk(gap_last >= QUIET, "R9 gap between pd frames", gap_last, QUIET);
        end
        wait (cmd_ready === 1'b1);
        repeat (20) @(negedge clk);
        #1;
        if (n == 2) chk(frames_done == f0 + 2, "R7 frame count", frames_done - f0, 2);
        else        chk(frames_done == f0 + 1, "R6 frame count", frames_done - f0, 1);
        chk(res_valid == 1'b0, "R6 no result", res_valid, 0);
    endtask

    task automatic do_wake();
        int f0;
        f0 = frames_done;
        send(3'd4);
        wait (frames_done == f0 + 1);
        @(negedge clk); #1;
        chk(falls_last == 16, "R8 wake falls", falls_last, 16);
        wait (cmd_ready === 1'b1);
        @(negedge clk); #1;
        chk(res_valid == 1'b0, "R8 no result", res_valid, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%0d exp=done", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] da, db;
        logic [15:0] wa, wbb;
        int f0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; res_ready = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R1 pins idle", {adc_cs_n, adc_sclk}, 3);
        chk(res_valid == 1'b0, "R1 no result", res_valid, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);

        // normal reads over a data sweep, R3 routing
        for (int i = 0; i < 24; i++) begin
            da = 12'((i * 397 + 5) & 12'hFFF);
            db = 12'(~da ^ 12'(i * 61));
            if (i == 0) begin da = 12'h000; db = 12'hFFF; end
            if (i == 1) begin da = 12'hFFF; db = 12'h000; end
            if (i == 2) begin da = 12'h800; db = 12'h7FF; end
            wa  = mk(1'b0, 1'b0, 1'b0, i[0], da);
            wbb = mk(1'b0, 1'b0, 1'b1, i[1], db);
            do_conv(1'b0, {wa, 16'h0}, wbb, da, db, i[0], i[1], 1'b0, i != 0, 1'b0, "R3 data");
        end

        // chained reads, arrival order alternates, R4 sorting
        for (int i = 0; i < 24; i++) begin
            da = 12'((i * 1237 + 77) & 12'hFFF);
            db = 12'((i * 311) ^ 12'hA5A);
            wa  = mk(1'b0, 1'b0, 1'b0, i[1], da);
            wbb = mk(1'b0, 1'b0, 1'b1, i[2], db);
            do_conv(1'b1, i[0] ? {wbb, wa} : {wa, wbb}, 16'h0, da, db, i[1], i[2], 1'b0,
                    1'b1, 1'b0, "R4 sorted");
        end

        // R5 error cases
        do_conv(1'b0, {mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h123), 16'h0},
                mk(1'b0, 1'b0, 1'b1, 1'b0, 12'h456), 12'h123, 12'h456, 1'b0, 1'b0, 1'b1,
                1'b1, 1'b0, "R5 lead data");
        do_conv(1'b0, {mk(1'b0, 1'b0, 1'b0, 1'b1, 12'h321), 16'h0},
                mk(1'b0, 1'b1, 1'b1, 1'b1, 12'h654), 12'h321, 12'h654, 1'b1, 1'b1, 1'b1,
                1'b1, 1'b0, "R5 zflag data");
        do_conv(1'b0, {mk(1'b0, 1'b0, 1'b1, 1'b0, 12'h0F0), 16'h0},
                mk(1'b0, 1'b0, 1'b1, 1'b0, 12'h00F), 12'h0F0, 12'h00F, 1'b0, 1'b0, 1'b1,
                1'b1, 1'b0, "R5 id data");
        do_conv(1'b1, {mk(1'b0, 1'b0, 1'b0, 1'b0, 12'hABC), mk(1'b0, 1'b0, 1'b0, 1'b1, 12'hDEF)},
                16'h0, 12'hABC, 12'hDEF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R5 chain data");

        // R11: result left pending while the next command is offered
        do_conv(1'b0, {mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h111), 16'h0},
                mk(1'b0, 1'b0, 1'b1, 1'b0, 12'h222), 12'h111, 12'h222, 1'b0, 1'b0, 1'b0,
                1'b1, 1'b1, "R11 first");
        f0 = frames_done;
        stream_a = {mk(1'b0, 1'b0, 1'b0, 1'b1, 12'h333), 16'h0};
        word_b   = mk(1'b0, 1'b0, 1'b1, 1'b1, 12'h444);
        cmd_valid = 1'b1; cmd_op = 3'd0;
        repeat (10) @(negedge clk);
        #1;
        chk(cmd_ready == 1'b0 && res_valid == 1'b1, "R11 held off", {cmd_ready, res_valid}, 1);
        chk(frames_done == f0 && adc_cs_n == 1'b1, "R11 no frame", frames_done - f0, 0);
        chk(res_data_a == 12'h111, "R11 stable", res_data_a, 12'h111);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait (res_valid === 1'b1);
        @(negedge clk); #1;
        chk(res_data_a == 12'h333 && res_data_b == 12'h444, "R11 second",
            {res_data_a, res_data_b}, 24'h333444);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;

        // partial power-down, wake, then convert: only quiet time applies
        do_pd(3'd2, 1);
        do_wake();
        do_conv(1'b0, {mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h5A5), 16'h0},
                mk(1'b0, 1'b0, 1'b1, 1'b1, 12'hA5A), 12'h5A5, 12'hA5A, 1'b0, 1'b1, 1'b0,
                1'b1, 1'b0, "R10 partial data");
        chk(gap_last < QUIET + WAKE, "R10 partial wake gap", gap_last, QUIET);

        // full power-down, wake, then convert: settle delay applies
        do_pd(3'd3, 2);
        do_wake();
        do_conv(1'b0, {mk(1'b0, 1'b0, 1'b0, 1'b1, 12'h0C3), 16'h0},
                mk(1'b0, 1'b0, 1'b1, 1'b0, 12'h3C0), 12'h0C3, 12'h3C0, 1'b1, 1'b0, 1'b0,
                1'b1, 1'b0, "R10 full data");
        chk(gap_last >= QUIET + WAKE, "R10 full wake gap", gap_last, QUIET + WAKE);

        // R12: unused op codes
        for (int op = 5; op < 8; op++) begin
            f0 = frames_done;
            send(3'(op));
            repeat (30) @(negedge clk);
            #1;
            chk(frames_done == f0 && res_valid == 1'b0 && cmd_ready == 1'b1 && adc_cs_n == 1'b1,
                "R12 ignored op", frames_done - f0, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule